// File: doc/BRIEF.md
# Threshold Alarm Unit

This block watches eight sensor sample streams and raises alarms when they cross programmed limits. There are four alarm channels. Three inertial channels, X, Y and Z, each take either an acceleration stream or an angle stream. One system channel takes either a supply reading or a temperature reading. Every stream is refreshed on one shared strobe, `smp_valid`.

Each channel compares its selected stream against a 16-bit threshold, and the comparison can be greater-than or less-than. An inertial channel can also run in rate-of-change mode. In that mode it compares the size of the change against a sample taken a programmed number of samples earlier. A channel that trips sets a sticky flag. Only the clear command removes a flag.

An indicator output shows whether any enabled channel holds a flag, and the level it drives when active can be chosen. A single 16-bit control word holds every per-channel setting. The thresholds and sample counts arrive on their own ports.

Top module: `alarm_watch_unit`

## Requirements
- R1: After reset all four flags are 0 and `alarm_ind` sits at its inactive level.
- R2: Control bits 3:0 enable channels X, Y, Z and S in that order. The flag for each channel sits at the same bit index in `flags`. A disabled channel never sets its flag.
- R3: Control bits 7:4 select the source for X, Y, Z and S. For X, Y and Z, 1 selects the angle stream and 0 the acceleration stream. For S, 1 selects the supply stream and 0 the temperature stream. The stream that is not selected has no effect.
- R4: Control bits 11:8 give the polarity for X, Y, Z and S. A value of 1 trips when the value is strictly greater than the threshold, and 0 when it is strictly less. Equality never trips.
- R5: In static mode, X, Y and Z compare value and threshold as two's complement numbers. S compares them as unsigned numbers.
- R6: Control bits 14:12 put X, Y and Z into rate-of-change mode when set. The change is the current sample minus the sample N strobes earlier, formed at 17 bits without wrap. N is the channel's 8-bit span, and a span of 0 acts as 1. The channel compares the unsigned size of that change against the threshold.
- R7: In rate-of-change mode a channel does not evaluate until N samples have been stored since reset. The same wait applies after any change to that channel's enable, source, mode or span.
- R8: A set flag stays set while the condition goes away and while the channel is disabled.
- R9: A `clr` pulse zeroes all flags on the next edge. It wins over a trip that happens in the same cycle.
- R10: Control bit 15 sets the indicator polarity: 1 means active high and 0 means active low. The indicator is active when a flag is set and that channel is enabled.
- R11: Comparisons happen only on edges where `smp_valid` is 1. A resulting flag is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | New sample on every stream |
| acc_x | input | 16 | X acceleration, two's complement |
| acc_y | input | 16 | Y acceleration, two's complement |
| acc_z | input | 16 | Z acceleration, two's complement |
| ang_x | input | 16 | X angle, two's complement |
| ang_y | input | 16 | Y angle, two's complement |
| ang_z | input | 16 | Z angle, two's complement |
| supply_lvl | input | 16 | Supply reading, unsigned |
| temp_lvl | input | 16 | Temperature reading, unsigned |
| ctrl | input | 16 | Control word (enable, select, polarity, mode, indicator) |
| thr_x | input | 16 | X threshold |
| thr_y | input | 16 | Y threshold |
| thr_z | input | 16 | Z threshold |
| thr_s | input | 16 | S threshold, unsigned |
| span_x | input | 8 | X rate-of-change span in samples |
| span_y | input | 8 | Y rate-of-change span in samples |
| span_z | input | 8 | Z rate-of-change span in samples |
| clr | input | 1 | Clear all flags |
| flags | output | 4 | Sticky flags: bit0 X, bit1 Y, bit2 Z, bit3 S |
| alarm_ind | output | 1 | Alarm indicator |

## Verification
The bench puts values exactly at a threshold. A comparison that is not strict would trip there. It also feeds a negative acceleration against a small positive threshold, and a large supply value against a threshold below it. A design that mixed up signed and unsigned comparison would then trip or stay quiet in the wrong case.

In rate-of-change mode the bench sends patterns that give different results depending on which past sample is used. The change from one sample to the next, the change from N samples back, a change across the 16-bit wrap, and the result after a span change all lead to different outcomes. A delta that is off by one sample, has wrapped, or skips the refill wait would therefore trip at a visible wrong point.

The bench also sends a clear and a trip in the same cycle. It disables a channel that holds a flag and checks that the flag stays while the indicator drops.

// File: rtl/alarm_watch_pkg.sv
`timescale 1ns/1ps
package alarm_watch_pkg;
   localparam int CTRL_W      = 16;
   localparam int NUM_CH      = 4;
   localparam int NUM_INERT   = 3;
   localparam int CH_SYS      = 3;
   localparam int EN_LSB      = 0;
   localparam int SEL_LSB     = 4;
   localparam int POL_LSB     = 8;
   localparam int DYN_LSB     = 12;
   localparam int IND_POL_BIT = 15;
endpackage

// File: rtl/alarm_hist.sv
`timescale 1ns/1ps
module alarm_hist #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8,
   parameter int CFG_W  = 11,
   parameter bit SIGNED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [CFG_W-1:0]    cfg,
   input  logic [CNT_W-1:0]    span,
   input  logic [DATA_W-1:0]   cur,
   output logic [DATA_W:0]     delta,
   output logic                ready
);
   localparam int HIST_D = 1 << CNT_W;
   localparam logic [CNT_W-1:0] FILL_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] ring [HIST_D];
   logic [CNT_W-1:0]  wptr;
   logic [CNT_W-1:0]  fill;
   logic [CNT_W-1:0]  n_eff;
   logic [CNT_W-1:0]  rd_idx;
   logic [CFG_W-1:0]  snap;
   logic              changed;
   logic [DATA_W-1:0] old;
   logic [DATA_W:0]   cur_x;
   logic [DATA_W:0]   old_x;

   assign changed = (cfg != snap);
   assign n_eff   = (span == '0) ? ONE : span;
   assign rd_idx  = wptr - n_eff;
   assign old     = ring[rd_idx];

   generate
      if (SIGNED) begin : g_sext
         assign cur_x = {cur[DATA_W-1], cur};
         assign old_x = {old[DATA_W-1], old};
      end else begin : g_zext
         assign cur_x = {1'b0, cur};
         assign old_x = {1'b0, old};
      end
   endgenerate

   assign delta = cur_x - old_x;
   assign ready = !changed && (fill >= n_eff);

   always_ff @(posedge clk) begin
      if (smp_valid) ring[wptr] <= cur;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         fill <= '0;
         snap <= '0;
      end else begin
         snap <= cfg;
         if (smp_valid) wptr <= wptr + ONE;
         if (changed) begin
            fill <= '0;
         end else if (smp_valid && (fill != FILL_MAX)) begin
            fill <= fill + ONE;
         end
      end
   end

   AST_FRESH_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg) |=> !ready); // R7
endmodule

// File: rtl/alarm_cmp.sv
`timescale 1ns/1ps
module alarm_cmp #(
   parameter int DATA_W = 16,
   parameter bit SIGNED = 1'b1
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W:0]   delta,
   input  logic              use_dyn,
   input  logic              pol_gt,
   input  logic [DATA_W-1:0] thr,
   output logic              over
);
   logic            st_gt, st_lt;
   logic            dy_gt, dy_lt;
   logic [DATA_W:0] mag;
   logic [DATA_W:0] thr_x;

   generate
      if (SIGNED) begin : g_scmp
         assign st_gt = $signed(value) > $signed(thr);
         assign st_lt = $signed(value) < $signed(thr);
      end else begin : g_ucmp
         assign st_gt = value > thr;
         assign st_lt = value < thr;
      end
   endgenerate

   assign mag   = delta[DATA_W] ? (~delta + 1'b1) : delta;
   assign thr_x = {1'b0, thr};
   assign dy_gt = mag > thr_x;
   assign dy_lt = mag < thr_x;

   always_comb begin
      if (use_dyn) over = pol_gt ? dy_gt : dy_lt;
      else         over = pol_gt ? st_gt : st_lt;
   end
endmodule

// File: rtl/alarm_chan.sv
`timescale 1ns/1ps
module alarm_chan #(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 8,
   parameter bit SIGNED  = 1'b1,
   parameter bit HAS_DYN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] src_lo,
   input  logic [DATA_W-1:0] src_hi,
   input  logic              en,
   input  logic              sel,
   input  logic              pol_gt,
   input  logic              dyn,
   input  logic [DATA_W-1:0] thr,
   input  logic [CNT_W-1:0]  span,
   output logic              hit
);
   localparam int CFG_W = CNT_W + 3;

   logic [DATA_W-1:0] cur;
   logic [DATA_W:0]   delta;
   logic              use_dyn;
   logic              eval_ok;
   logic              over;

   assign cur = sel ? src_hi : src_lo;

   generate
      if (HAS_DYN) begin : g_dyn
         logic ready;
         alarm_hist #(
            .DATA_W(DATA_W), .CNT_W(CNT_W), .CFG_W(CFG_W), .SIGNED(SIGNED)
         ) u_hist (
            .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
            .cfg({en, sel, dyn, span}), .span(span), .cur(cur),
            .delta(delta), .ready(ready)
         );
         assign use_dyn = dyn;
         assign eval_ok = !dyn || ready;
      end else begin : g_static
         logic unused_cfg;
         assign unused_cfg = ^{dyn, span};
         assign delta   = '0;
         assign use_dyn = 1'b0;
         assign eval_ok = 1'b1;
      end
   endgenerate

   alarm_cmp #(.DATA_W(DATA_W), .SIGNED(SIGNED)) u_cmp (
      .value(cur), .delta(delta), .use_dyn(use_dyn),
      .pol_gt(pol_gt), .thr(thr), .over(over)
   );

   assign hit = smp_valid && en && eval_ok && over;
endmodule

// File: rtl/alarm_watch_unit.sv
`timescale 1ns/1ps
module alarm_watch_unit
   import alarm_watch_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] acc_x,
   input  logic [DATA_W-1:0] acc_y,
   input  logic [DATA_W-1:0] acc_z,
   input  logic [DATA_W-1:0] ang_x,
   input  logic [DATA_W-1:0] ang_y,
   input  logic [DATA_W-1:0] ang_z,
   input  logic [DATA_W-1:0] supply_lvl,
   input  logic [DATA_W-1:0] temp_lvl,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [DATA_W-1:0] thr_x,
   input  logic [DATA_W-1:0] thr_y,
   input  logic [DATA_W-1:0] thr_z,
   input  logic [DATA_W-1:0] thr_s,
   input  logic [CNT_W-1:0]  span_x,
   input  logic [CNT_W-1:0]  span_y,
   input  logic [CNT_W-1:0]  span_z,
   input  logic              clr,
   output logic [NUM_CH-1:0] flags,
   output logic              alarm_ind
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if ((CNT_W < 1) || (CNT_W > 10)) begin : g_bad_cnt_w
         $error("CNT_W must lie in 1..10");
      end
   endgenerate

   logic [DATA_W-1:0] acc_v  [NUM_INERT];
   logic [DATA_W-1:0] ang_v  [NUM_INERT];
   logic [DATA_W-1:0] thr_v  [NUM_INERT];
   logic [CNT_W-1:0]  span_v [NUM_INERT];
   logic [NUM_CH-1:0] hits;
   logic [NUM_CH-1:0] en_v;
   logic              any_on;

   assign acc_v[0]  = acc_x;  assign acc_v[1]  = acc_y;  assign acc_v[2]  = acc_z;
   assign ang_v[0]  = ang_x;  assign ang_v[1]  = ang_y;  assign ang_v[2]  = ang_z;
   assign thr_v[0]  = thr_x;  assign thr_v[1]  = thr_y;  assign thr_v[2]  = thr_z;
   assign span_v[0] = span_x; assign span_v[1] = span_y; assign span_v[2] = span_z;
   assign en_v = ctrl[EN_LSB +: NUM_CH];

   generate
      for (genvar i = 0; i < NUM_INERT; i++) begin : g_inert
         alarm_chan #(
            .DATA_W(DATA_W), .CNT_W(CNT_W), .SIGNED(1'b1), .HAS_DYN(1'b1)
         ) u_chan (
            .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
            .src_lo(acc_v[i]), .src_hi(ang_v[i]),
            .en(ctrl[EN_LSB + i]), .sel(ctrl[SEL_LSB + i]),
            .pol_gt(ctrl[POL_LSB + i]), .dyn(ctrl[DYN_LSB + i]),
            .thr(thr_v[i]), .span(span_v[i]), .hit(hits[i])
         );
      end
   endgenerate

   alarm_chan #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .SIGNED(1'b0), .HAS_DYN(1'b0)
   ) u_sys (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .src_lo(temp_lvl), .src_hi(supply_lvl),
      .en(ctrl[EN_LSB + CH_SYS]), .sel(ctrl[SEL_LSB + CH_SYS]),
      .pol_gt(ctrl[POL_LSB + CH_SYS]), .dyn(1'b0),
      .thr(thr_s), .span('0), .hit(hits[CH_SYS])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flags <= '0;
      else if (clr) flags <= '0;
      else          flags <= flags | hits;
   end

   assign any_on    = |(flags & en_v);
   assign alarm_ind = ctrl[IND_POL_BIT] ? any_on : !any_on;

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flags == '0)); // R9
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags & $past(flags)) == $past(flags))); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !clr) |=> (flags == $past(flags))); // R11
   AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags & ~$past(flags) & ~$past(en_v)) == '0)); // R2
endmodule

// File: tb/test_alarm_watch_unit.sv
`timescale 1ns/1ps
module test_alarm_watch_unit;
   localparam time CLK_HALF = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] acc_x = '0, acc_y = '0, acc_z = '0;
   logic [15:0] ang_x = '0, ang_y = '0, ang_z = '0;
   logic [15:0] supply_lvl = '0, temp_lvl = '0;
   logic [15:0] ctrl = 16'h8000;
   logic [15:0] thr_x = '0, thr_y = '0, thr_z = '0, thr_s = '0;
   logic [7:0]  span_x = 8'd1, span_y = 8'd1, span_z = 8'd1;
   logic        clr = 1'b0;
   logic [3:0]  flags;
   logic        alarm_ind;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #CLK_HALF clk = ~clk;

   alarm_watch_unit i_alarm_watch_unit (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
      .ang_x(ang_x), .ang_y(ang_y), .ang_z(ang_z),
      .supply_lvl(supply_lvl), .temp_lvl(temp_lvl), .ctrl(ctrl),
      .thr_x(thr_x), .thr_y(thr_y), .thr_z(thr_z), .thr_s(thr_s),
      .span_x(span_x), .span_y(span_y), .span_z(span_z),
      .clr(clr), .flags(flags), .alarm_ind(alarm_ind)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic strobe();
      @(negedge clk) smp_valid = 1'b1;
      @(negedge clk) smp_valid = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
   endtask

   task automatic set_cfg(input logic [15:0] c);
      @(negedge clk) ctrl = c;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 flags after reset", 32'(flags), 32'h0);
      check("R1 indicator inactive", 32'(alarm_ind), 32'h0);
   endtask

   task automatic t_static_z();
      thr_z = 16'h2000;
      set_cfg(16'h8044);
      ang_z = 16'h3000; acc_z = 16'h0000; strobe();
      check("R3 accel ignored when angle selected", 32'(flags), 32'h0);
      ang_z = 16'h2000; strobe();
      check("R4 equal does not trip", 32'(flags), 32'h0);
      ang_z = 16'h1000; strobe();
      check("R4 less-than trips Z", 32'(flags), 32'h4);
      check("R10 indicator active high", 32'(alarm_ind), 32'h1);
      ang_z = 16'h3000; strobe();
      check("R8 flag sticky", 32'(flags), 32'h4);
      set_cfg(16'h8040);
      check("R8 flag held while disabled", 32'(flags), 32'h4);
      check("R10 indicator ignores disabled flag", 32'(alarm_ind), 32'h0);
      clear_flags();
      check("R9 clear zeroes flags", 32'(flags), 32'h0);
   endtask

   task automatic t_signed_x();
      thr_x = 16'h0100;
      set_cfg(16'h8101);
      acc_x = 16'hFF00; strobe();
      check("R5 negative below positive threshold", 32'(flags), 32'h0);
      acc_x = 16'h0200; strobe();
      check("R5 greater-than trips X", 32'(flags), 32'h1);
      clear_flags();
   endtask

   task automatic t_system();
      thr_s = 16'h5000;
      set_cfg(16'h8888);
      supply_lvl = 16'h4000; temp_lvl = 16'h9000; strobe();
      check("R3 temperature ignored when supply selected", 32'(flags), 32'h0);
      supply_lvl = 16'h8000; strobe();
      check("R5 unsigned supply compare", 32'(flags), 32'h8);
      clear_flags();
      set_cfg(16'h8808);
      supply_lvl = 16'h0000; temp_lvl = 16'h9000; strobe();
      check("R3 temperature selected", 32'(flags), 32'h8);
      clear_flags();
      supply_lvl = '0; temp_lvl = '0;
   endtask

   task automatic t_disabled();
      thr_x = '0; thr_y = '0; thr_z = '0; thr_s = '0;
      set_cfg(16'h8F00);
      acc_x = 16'h7000; acc_y = 16'h7000; acc_z = 16'h7000;
      ang_x = 16'h7000; ang_y = 16'h7000; ang_z = 16'h7000;
      supply_lvl = 16'h7000; temp_lvl = 16'h7000;
      strobe(); strobe();
      check("R2 disabled channels stay quiet", 32'(flags), 32'h0);
      acc_x = '0; acc_y = '0; acc_z = '0; ang_x = '0; ang_y = '0; ang_z = '0;
      supply_lvl = '0; temp_lvl = '0;
   endtask

   task automatic t_active_low();
      thr_z = 16'h2000; ang_z = 16'h3000;
      set_cfg(16'h0044);
      check("R10 active-low idle level", 32'(alarm_ind), 32'h1);
      ang_z = 16'h0000; strobe();
      check("R10 active-low asserted", 32'(alarm_ind), 32'h0);
      clear_flags();
      check("R9 clear restores indicator", 32'(alarm_ind), 32'h1);
   endtask

   task automatic t_clear_and_idle();
      thr_z = 16'h2000; ang_z = 16'h0000;
      set_cfg(16'h8044);
      @(negedge clk) begin smp_valid = 1'b1; clr = 1'b1; end
      @(negedge clk) begin smp_valid = 1'b0; clr = 1'b0; end
      check("R9 clear wins over same-cycle trip", 32'(flags), 32'h0);
      repeat (5) @(negedge clk);
      check("R11 no compare without strobe", 32'(flags), 32'h0);
      strobe();
      check("R11 trip visible after strobe", 32'(flags), 32'h4);
      clear_flags();
      ang_z = 16'h3000;
   endtask

   task automatic t_dynamic();
      thr_y = 16'h0100; span_y = 8'd1; acc_y = '0;
      set_cfg(16'hA202);
      strobe(); strobe();
      check("R6 flat input no trip", 32'(flags), 32'h0);
      span_y = 8'd2; @(negedge clk); @(negedge clk);
      acc_y = 16'h0800; strobe(); strobe(); strobe();
      check("R7 refill after span change", 32'(flags), 32'h0);
      acc_y = 16'h0000; strobe();
      check("R6 negative change by magnitude", 32'(flags), 32'h2);
      clear_flags();
      span_y = 8'd3; @(negedge clk); @(negedge clk);
      acc_y = 16'h0400; strobe();
      acc_y = 16'h0000; strobe(); strobe();
      acc_y = 16'h0400; strobe();
      check("R6 compares N samples back", 32'(flags), 32'h0);
      strobe();
      check("R6 trips on change over span", 32'(flags), 32'h2);
      clear_flags();
      span_y = 8'd0; @(negedge clk); @(negedge clk);
      acc_y = 16'h0000; strobe();
      check("R7 first sample not evaluated", 32'(flags), 32'h0);
      acc_y = 16'h0400; strobe();
      check("R6 span zero acts as one", 32'(flags), 32'h2);
      clear_flags();
      thr_y = 16'hFFFF; span_y = 8'd1; @(negedge clk); @(negedge clk);
      acc_y = 16'h8000; strobe();
      acc_y = 16'h7FFF; strobe();
      check("R6 full swing equals threshold", 32'(flags), 32'h0);
      thr_y = 16'hFFFE;
      acc_y = 16'h8000; strobe();
      check("R6 17-bit change no wrap", 32'(flags), 32'h2);
      clear_flags();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_static_z();
      t_signed_x();
      t_system();
      t_disabled();
      t_active_low();
      t_clear_and_idle();
      t_dynamic();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_HALF * 2 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule